// File: doc/BRIEF.md
# Page-mode parallel ROM reader

This block is a synchronous front end for an asynchronous parallel ROM that supports fast reads within a page. A request gives a start element address, an element count and an organization flag (16-bit words or single bytes). The block then walks the addresses in ascending order and drives the ROM's address lines, chip and output enables, and width select. It captures each element into an output register and presents it on a valid/ready stream.

All analog timing figures are parameters in picoseconds. They are turned into whole clock cycles by rounding up, with a floor of one cycle. The first access of a request, and any access that has just stepped into a new page, waits the long random-access time. Later accesses within the same page wait only the short in-page time.

In byte mode, the pin that carries data bit 15 in word mode becomes the lowest address bit. The block then drives it as an output and ignores the upper data byte. After the final element, both enables return high. A recovery gap then follows before the bus can be driven again.

Top module: `pgrom_rd`

## Requirements
- R1: While reset is held and just after it, `rom_ce_n` and `rom_oe_n` are 1, `out_valid` is 0 and `req_ready` is 1.
- R2: A request with `req_len` = L yields exactly L+1 elements for consecutive addresses starting at `req_addr`, in ascending order. `out_last` is 1 on the final element only.
- R3: The first element of a request appears on `out_valid` exactly N_RAND cycles after the accepting clock edge. N_RAND is the largest of the address, chip-enable and output-enable access times, each converted to cycles; with the defaults it is 10.
- R4: A following element in the same page is captured N_PAGE cycles after the previous one when the sink is ready. N_PAGE is 3 with the defaults.
- R5: An element whose address starts a new page is captured N_RAND cycles after the previous one. A page is 8 words: word address bits [2:0] wrap to 0. In byte mode a page is 16 bytes: byte address bits [3:0] wrap to 0.
- R6: Word mode (`req_byte`=0) drives `rom_wsel`=1 and `rom_am1_oe`=0, places the word address on `rom_a`, and returns all 16 bits of `rom_dq`.
- R7: Byte mode (`req_byte`=1) drives `rom_wsel`=0 and `rom_am1_oe`=1. The byte address bit 0 goes on `rom_am1` and byte address bits [22:1] on `rom_a`. The element is `{8'h00, rom_dq[7:0]}`, so `rom_dq[15:8]` has no effect.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_last` stay unchanged and the ROM address does not advance. No element is lost or repeated.
- R9: After the final capture, `rom_ce_n` and `rom_oe_n` go to 1. `rom_oe_n` then stays high for at least N_DF cycles before any new access; N_DF is 2 with the defaults.
- R10: `req_ready` is 1 only while no request is in progress, and in that state the ROM is in standby (`rom_ce_n`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | ROM_AW+1 | Start element address (word or byte index) |
| req_len | input | LEN_W | Element count minus one |
| req_byte | input | 1 | 1 = byte organization, 0 = word organization |
| rom_a | output | ROM_AW | ROM address lines above the byte-select bit |
| rom_am1 | output | 1 | Byte-select address bit, shared with data bit 15 |
| rom_am1_oe | output | 1 | Drive enable for the shared pin |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| rom_wsel | output | 1 | Width select, 1 = word |
| rom_dq | input | DQ_W | ROM data pins |
| out_valid | output | 1 | Element available |
| out_ready | input | 1 | Sink takes element |
| out_data | output | DQ_W | Captured element |
| out_last | output | 1 | Final element of the request |

## Verification
Every result of this block is due a fixed number of edges after its cause. The first element is due N_RAND edges after the accepting edge. A same-page element is due N_PAGE edges after its predecessor, and a page-crossing element N_RAND edges after it. The bus gap is at least N_DF cycles after the last capture. The bench notes the cycle of acceptance and of each element it sees. It compares these spacings with values derived from the nanosecond figures. Those spacings are checked only while the sink never stalls.

The ROM stub returns a poison word whenever the address, the enables or the shared pin have not been steady long enough. A capture that comes one cycle early therefore shows up as a data mismatch. All sampling and driving of inputs happens on the falling clock edge, or by nonblocking update on the rising edge, away from the design's capture edge.

// File: rtl/pgrom_pkg.sv
package pgrom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_GAP  = 2'd2
   } pgrom_st_e;

   // Convert a time in ps into whole cycles, rounding up, minimum one cycle.
   function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                             input int unsigned clk_ps);
      int unsigned n;
      n = (t_ps + clk_ps - 1) / clk_ps;
      return (n < 1) ? 1 : n;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pgrom_timer.sv
// Down-counting wait timer: done is high in the last cycle of a loaded wait.
module pgrom_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(1);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q > CNT_W'(1)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pgrom_seq.sv
// Address sequencer: element address, remaining count, organization, page-end detect.
module pgrom_seq #(
   parameter int unsigned EA_W   = 23,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned WPG_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [EA_W-1:0]  start_addr,
   input  logic [LEN_W-1:0] start_len,
   input  logic             start_byte,
   input  logic             step,
   output logic [EA_W-1:0]  addr,
   output logic             byte_mode,
   output logic             rem_zero,
   output logic             at_page_end
);
   localparam int unsigned BPG_W = WPG_W + 1;

   logic [LEN_W-1:0] rem_q;
   logic             word_end;
   logic             byte_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr      <= '0;
         rem_q     <= '0;
         byte_mode <= 1'b0;
      end else if (start) begin
         addr      <= start_addr;
         rem_q     <= start_len;
         byte_mode <= start_byte;
      end else if (step) begin
         addr      <= addr + EA_W'(1);
         rem_q     <= rem_q - LEN_W'(1);
      end
   end

   assign rem_zero    = (rem_q == '0);
   assign word_end    = &addr[WPG_W-1:0];
   assign byte_end    = &addr[BPG_W-1:0];
   assign at_page_end = byte_mode ? byte_end : word_end;
endmodule

// File: rtl/pgrom_lane.sv
// Output register with per-lane masking of the upper byte in byte mode.
module pgrom_lane #(
   parameter int unsigned DQ_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap,
   input  logic            cap_last,
   input  logic            byte_mode,
   input  logic [DQ_W-1:0] dq,
   input  logic            out_ready,
   output logic            out_valid,
   output logic [DQ_W-1:0] out_data,
   output logic            out_last
);
   localparam int unsigned HALF = DQ_W / 2;

   logic [DQ_W-1:0] dq_m;

   genvar gi;
   generate
      for (gi = 0; gi < DQ_W; gi++) begin : g_lane
         if (gi < HALF) begin : g_lo
            assign dq_m[gi] = dq[gi];
         end else begin : g_hi
            assign dq_m[gi] = dq[gi] & ~byte_mode;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (cap) begin
         out_valid <= 1'b1;
         out_data  <= dq_m;
         out_last  <= cap_last;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pgrom_rd.sv
module pgrom_rd
   import pgrom_pkg::*;
#(
   parameter int unsigned CLK_PS    = 10000,
   parameter int unsigned T_ADDR_PS = 100000,
   parameter int unsigned T_CE_PS   = 100000,
   parameter int unsigned T_PAGE_PS = 30000,
   parameter int unsigned T_OE_PS   = 30000,
   parameter int unsigned T_DF_PS   = 20000,
   parameter int unsigned ROM_AW    = 22,
   parameter int unsigned DQ_W      = 16,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned WPG_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ROM_AW:0]   req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_byte,
   output logic [ROM_AW-1:0] rom_a,
   output logic              rom_am1,
   output logic              rom_am1_oe,
   output logic              rom_ce_n,
   output logic              rom_oe_n,
   output logic              rom_wsel,
   input  logic [DQ_W-1:0]   rom_dq,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DQ_W-1:0]   out_data,
   output logic              out_last
);
   localparam int unsigned EA_W   = ROM_AW + 1;
   localparam int unsigned N_RAND = max2(max2(ps_to_cyc(T_ADDR_PS, CLK_PS),
                                              ps_to_cyc(T_CE_PS, CLK_PS)),
                                         ps_to_cyc(T_OE_PS, CLK_PS));
   localparam int unsigned N_PAGE = ps_to_cyc(T_PAGE_PS, CLK_PS);
   localparam int unsigned N_DF   = ps_to_cyc(T_DF_PS, CLK_PS);
   localparam int unsigned N_MAX  = max2(max2(N_RAND, N_PAGE), N_DF);
   localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

   generate
      if (CLK_PS == 0) begin : g_chk_clk
         $error("pgrom_rd: CLK_PS must be non-zero");
      end
      if ((DQ_W < 2) || (DQ_W % 2 != 0)) begin : g_chk_dq
         $error("pgrom_rd: DQ_W must be even and at least 2");
      end
      if (ROM_AW <= WPG_W + 1) begin : g_chk_aw
         $error("pgrom_rd: ROM_AW must exceed the page index width");
      end
      if (LEN_W < 1) begin : g_chk_len
         $error("pgrom_rd: LEN_W must be at least 1");
      end
   endgenerate

   pgrom_st_e         st_q;
   logic              accept;
   logic              cap;
   logic              t_done;
   logic              t_load;
   logic [CNT_W-1:0]  t_val;
   logic [EA_W-1:0]   addr;
   logic              byte_mode;
   logic              rem_zero;
   logic              at_page_end;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign cap       = (st_q == ST_ACC) && t_done && (!out_valid || out_ready);

   always_comb begin
      t_load = 1'b0;
      t_val  = CNT_W'(N_RAND);
      if (accept) begin
         t_load = 1'b1;
         t_val  = CNT_W'(N_RAND);
      end else if (cap) begin
         t_load = 1'b1;
         if (rem_zero)         t_val = CNT_W'(N_DF);
         else if (at_page_end) t_val = CNT_W'(N_RAND);
         else                  t_val = CNT_W'(N_PAGE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept)           st_q <= ST_ACC;
            ST_ACC:  if (cap && rem_zero)  st_q <= ST_GAP;
            ST_GAP:  if (t_done)           st_q <= ST_IDLE;
            default:                       st_q <= ST_IDLE;
         endcase
      end
   end

   pgrom_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   pgrom_seq #(.EA_W(EA_W), .LEN_W(LEN_W), .WPG_W(WPG_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_addr  (req_addr),
      .start_len   (req_len),
      .start_byte  (req_byte),
      .step        (cap && !rem_zero),
      .addr        (addr),
      .byte_mode   (byte_mode),
      .rem_zero    (rem_zero),
      .at_page_end (at_page_end)
   );

   pgrom_lane #(.DQ_W(DQ_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap),
      .cap_last  (rem_zero),
      .byte_mode (byte_mode),
      .dq        (rom_dq),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   assign rom_ce_n   = (st_q != ST_ACC);
   assign rom_oe_n   = (st_q != ST_ACC);
   assign rom_wsel   = ~byte_mode;
   assign rom_am1_oe = byte_mode;
   assign rom_am1    = addr[0];
   assign rom_a      = byte_mode ? addr[EA_W-1:1] : addr[ROM_AW-1:0];
endmodule

// File: rtl/pgrom_rd_chk.sv
module pgrom_rd_chk
   import pgrom_pkg::*;
#(
   parameter int unsigned CLK_PS  = 10000,
   parameter int unsigned T_DF_PS = 20000,
   parameter int unsigned ROM_AW  = 22,
   parameter int unsigned DQ_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ROM_AW-1:0] rom_a,
   input logic              rom_am1,
   input logic              rom_am1_oe,
   input logic              rom_ce_n,
   input logic              rom_oe_n,
   input logic              rom_wsel,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DQ_W-1:0]   out_data,
   input logic              out_last
);
   localparam int unsigned N_DF = ps_to_cyc(T_DF_PS, CLK_PS);

   logic [7:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hi_cnt <= 8'hFF;
      else if (!rom_oe_n)    hi_cnt <= '0;
      else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
   end

   a_r10_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rom_ce_n && rom_oe_n));

   a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !req_ready) |=> ($stable(rom_a) && $stable(rom_am1)));

   a_r6_word_pin: assert property (@(posedge clk) disable iff (!rst_n)
      rom_wsel |-> !rom_am1_oe);

   a_r7_byte_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_wsel |-> rom_am1_oe);

   a_r9_bus_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rom_oe_n) |-> (hi_cnt >= 8'(N_DF)));

   logic unused_ok;
   assign unused_ok = req_valid;
endmodule

bind pgrom_rd pgrom_rd_chk #(
   .CLK_PS  (CLK_PS),
   .T_DF_PS (T_DF_PS),
   .ROM_AW  (ROM_AW),
   .DQ_W    (DQ_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rom_a      (rom_a),
   .rom_am1    (rom_am1),
   .rom_am1_oe (rom_am1_oe),
   .rom_ce_n   (rom_ce_n),
   .rom_oe_n   (rom_oe_n),
   .rom_wsel   (rom_wsel),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .out_last   (out_last)
);

// File: tb/pgrom_rd_tb.sv
`timescale 1ns/1ps
module pgrom_rd_tb;
   // Timing derived from ns figures at a 10 ns clock, rounded up
   localparam int R_CYC  = (100 + 9) / 10;
   localparam int P_CYC  = (30 + 9) / 10;
   localparam int OE_CYC = (30 + 9) / 10;
   localparam int DF_CYC = (20 + 9) / 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [22:0] req_addr = '0;
   logic [7:0]  req_len = '0;
   logic        req_byte = 1'b0;
   logic [21:0] rom_a;
   logic        rom_am1, rom_am1_oe, rom_ce_n, rom_oe_n, rom_wsel;
   logic [15:0] rom_dq;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_data;
   logic        out_last;

   always #5 clk = ~clk;

   pgrom_rd u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
      .rom_a(rom_a), .rom_am1(rom_am1), .rom_am1_oe(rom_am1_oe),
      .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_wsel(rom_wsel),
      .rom_dq(rom_dq), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int acc_cyc = 0;
   int last_cyc = 0;
   bit chk_lat = 1'b1;
   bit stall_on = 1'b0;
   bit cur_byte = 1'b0;
   bit done_flag = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] wfun(input logic [21:0] wa);
      return wa[15:0] ^ {wa[21:16], wa[21:12]} ^ 16'h3C5A;
   endfunction

   function automatic logic [7:0] bfun(input logic [22:0] ba);
      logic [15:0] w;
      w = wfun(ba[22:1]);
      return ba[0] ? w[15:8] : w[7:0];
   endfunction

   // ---------------- cycle-level ROM stub ----------------
   int age_up = 0, age_lo = 0, age_en = 0;
   logic [22:0] p_up = '0;
   logic [3:0]  p_lo = '0;
   logic [1:0]  p_en = 2'b11;
   logic [22:0] c_up;
   logic [3:0]  c_lo;

   assign c_up = {rom_a[21:3], rom_wsel, rom_am1_oe, rom_ce_n, 1'b0};
   assign c_lo = {rom_a[2:0], rom_am1 & rom_am1_oe};

   always @(posedge clk) begin
      age_up <= (c_up != p_up) ? 1 : ((age_up < 1000) ? age_up + 1 : age_up);
      age_lo <= (c_lo != p_lo) ? 1 : ((age_lo < 1000) ? age_lo + 1 : age_lo);
      age_en <= ({rom_ce_n, rom_oe_n} != p_en) ? 1 : ((age_en < 1000) ? age_en + 1 : age_en);
      p_up <= c_up;
      p_lo <= c_lo;
      p_en <= {rom_ce_n, rom_oe_n};
   end

   always_comb begin
      logic ok;
      ok = !rom_ce_n && !rom_oe_n && (age_up >= R_CYC - 1) && (age_lo >= P_CYC - 1)
           && (age_en >= OE_CYC - 1) && (age_en >= R_CYC - 1 || age_up < age_en)
           && (rom_wsel != rom_am1_oe);
      if (!ok)          rom_dq = 16'hDEAD;
      else if (rom_wsel) rom_dq = wfun(rom_a);
      else               rom_dq = {8'hA5, bfun({rom_a, rom_am1})};
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [15:0] d;
      bit          last;
      int          lat;
      bit          first;
      string       dtag;
      string       ltag;
   } exp_t;
   exp_t q[$];

   task automatic send(input logic [22:0] a, input logic [7:0] len, input bit byt);
      @(negedge clk);
      req_addr  = a;
      req_len   = len;
      req_byte  = byt;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      acc_cyc  = cyc + 1;
      cur_byte = byt;
      for (int i = 0; i <= int'(len); i++) begin
         exp_t e;
         logic [22:0] ea;
         ea      = a + 23'(i);
         e.d     = byt ? {8'h00, bfun(ea)} : wfun(ea[21:0]);
         e.last  = (i == int'(len));
         e.first = (i == 0);
         e.dtag  = byt ? "R7" : "R6";
         if (i == 0) begin
            e.lat = R_CYC; e.ltag = "R3";
         end else if (byt ? (ea[3:0] == 4'h0) : (ea[2:0] == 3'h0)) begin
            e.lat = R_CYC; e.ltag = "R5";
         end else begin
            e.lat = P_CYC; e.ltag = "R4";
         end
         q.push_back(e);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      while (q.size() != 0) @(negedge clk);
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor
   bit          held_v = 1'b0;
   logic [15:0] held_d = '0;
   int          oe_hi = 1000;
   bit          prev_ce_n = 1'b1;
   bit          prev_rdy = 1'b1;

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (held_v)
               chk(out_valid && out_data == held_d, "R8", "held element", int'(out_data), int'(held_d));
            held_v = out_valid && !out_ready;
            held_d = out_data;
            if (out_valid && out_ready) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R2", "unexpected element", int'(out_data), 0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  chk(out_data == e.d, e.dtag, "data", int'(out_data), int'(e.d));
                  chk(out_last == e.last, "R2", "last flag", int'(out_last), int'(e.last));
                  if (chk_lat)
                     chk(cyc - (e.first ? acc_cyc : last_cyc) == e.lat, e.ltag, "latency",
                         cyc - (e.first ? acc_cyc : last_cyc), e.lat);
                  last_cyc = cyc;
               end
            end
            if (!rom_oe_n) begin
               if (oe_hi > 0) chk(oe_hi >= DF_CYC, "R9", "oe high gap", oe_hi, DF_CYC);
               oe_hi = 0;
            end else begin
               oe_hi++;
            end
            if (prev_ce_n && !rom_ce_n) begin
               if (cur_byte) chk(!rom_wsel && rom_am1_oe, "R7", "byte pins", {rom_wsel, rom_am1_oe}, 2'b01);
               else          chk(rom_wsel && !rom_am1_oe, "R6", "word pins", {rom_wsel, rom_am1_oe}, 2'b10);
            end
            if (req_ready && !prev_rdy)
               chk(rom_ce_n && rom_oe_n, "R9", "standby after request", {rom_ce_n, rom_oe_n}, 2'b11);
            if (req_ready && q.size() == 0 && !out_valid && !prev_rdy)
               chk(rom_ce_n, "R10", "ready only in standby", int'(rom_ce_n), 1);
            prev_ce_n = rom_ce_n;
            prev_rdy  = req_ready;
         end
      end
   end

   // sink
   logic [7:0] lf = 8'h5B;
   initial begin
      forever begin
         @(posedge clk);
         lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         out_ready <= stall_on ? (lf[0] & lf[2]) : 1'b1;
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   // stimulus
   initial begin
      repeat (3) @(negedge clk);
      chk(rom_ce_n && rom_oe_n, "R1", "enables in reset", {rom_ce_n, rom_oe_n}, 2'b11);
      chk(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1", "req_ready after reset", int'(req_ready), 1);
      chk(rom_ce_n && rom_oe_n && !out_valid, "R1", "idle after reset",
          {rom_ce_n, rom_oe_n, out_valid}, 3'b110);

      // in-page word run (R2 R3 R4 R6)
      send(23'h10, 8'd3, 1'b0);      wait_done();
      // word run crossing a page (R5)
      send(23'h105, 8'd5, 1'b0);     wait_done();
      // byte run crossing a 16-byte page (R7 R5)
      send(23'h2003, 8'd19, 1'b0 | 1'b1); wait_done();
      // single element (R2)
      send(23'h40, 8'd0, 1'b1);      wait_done();
      // back-to-back requests, mode switch (R9 R10)
      send(23'h200, 8'd1, 1'b0);
      send(23'h301, 8'd2, 1'b1);     wait_done();

      // backpressure (R8)
      chk_lat  = 1'b0;
      stall_on = 1'b1;
      send(23'h1F0, 8'd20, 1'b0);
      send(23'h77, 8'd30, 1'b1);     wait_done();
      stall_on = 1'b0;
      repeat (4) @(negedge clk);
      chk(rom_ce_n && req_ready && q.size() == 0, "R9", "standby at end",
          {rom_ce_n, req_ready}, 2'b11);

      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule